// File: doc/BRIEF.md
# Multi-Domain Power Status Register

This block is one 8-bit power-management register. A simple register bus reads and writes it. The bus has an address, a write enable, write data and read data that is driven without a clock. The register holds four things:

- a software scratch flag that only the standby-rail reset clears;
- a 2-bit lock-time select that also drives an output pin, unless an external override replaces it;
- a sticky flag for a reset-button press;
- a sticky flag for a thermal-trip event.

Software clears each sticky flag by writing 1 to it. Each field has its own reset domain. The standby-rail reset (`rsm_rst_n_i`, asynchronous) clears the whole register. The core warm reset (`warm_rst_n_i`, synchronous, active low) clears everything except the scratch flag. The platform reset never clears any field. It only qualifies the thermal-trip event.

The event inputs are asynchronous and pass through a synchronizer. A small three-state qualifier machine then watches each event. The states are `QS_BLOCKED` (qualifier false), `QS_READY` (qualified, input idle) and `QS_ACTIVE` (qualified, input held). The transitions are:

- any state goes to `QS_BLOCKED` when the qualifier drops;
- `QS_BLOCKED` goes to `QS_READY` when the qualifier rises and the input is idle;
- `QS_BLOCKED` goes to `QS_ACTIVE` when the qualifier rises and the input is already held, and no event fires;
- `QS_READY` goes to `QS_ACTIVE` when the input rises, and this fires the event;
- `QS_ACTIVE` goes to `QS_READY` when the input is released.

Only the `QS_READY` to `QS_ACTIVE` transition sets a status flag. An input that is already held when its qualifier comes true therefore never sets a flag.

Top module: `pm_status_reg`

## Requirements
- R1: After `rsm_rst_n_i` is asserted, a read at offset A2h returns 00h. Reads at any other offset return 00h. Reads have no side effects.
- R2: Bit 7 is a read/write scratch flag. It keeps its value through warm reset and platform reset. Only a write at A2h or the standby-rail reset changes it.
- R3: Bits 6:5 are a read/write lock-time select. Code 00 is at least 30.7 µs, 01 at least 61.4 µs, 10 at least 122.8 µs, and 11 is 42 to 48 µs. When no override is active, `lock_sel_o` equals bits 6:5. Warm reset clears them and platform reset does not.
- R4: While `lock_ovr_en_i` is 1, `lock_sel_o` equals `lock_ovr_i`, whatever bits 6:5 hold.
- R5: A rising edge of `rst_btn_i` while `pwr_ok_i` is 1 sets bit 4. Writing 1 to bit 4 at A2h clears it. Writing 0 leaves it unchanged.
- R6: While `pwr_ok_i` is 0, the button cannot set bit 4. A button held across the return of `pwr_ok_i` does not set it either.
- R7: A rising edge of `therm_trip_i` sets bit 3 only while `plt_rst_n_i` is 1 and `slp_state_i` is S0 (00) or S1 (01). Codes 10 (S3) and 11 (S4/S5) block it. Writing 1 to bit 3 clears it.
- R8: Asserting platform reset does not clear bits 4 or 3. Warm reset clears bits 6:3.
- R9: When a set event and a write-1-clear of the same bit fall in the same cycle, the bit ends set.
- R10: Bits 2:0 always read 0 and ignore writes. Writes at other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rsm_rst_n_i | input | 1 | Standby-rail reset, asynchronous, active low |
| warm_rst_n_i | input | 1 | Core warm reset, synchronous, active low |
| plt_rst_n_i | input | 1 | Platform reset, active low (qualifier only) |
| pwr_ok_i | input | 1 | Main-rail power good |
| rst_btn_i | input | 1 | Reset button, active high |
| therm_trip_i | input | 1 | Thermal trip, active high |
| slp_state_i | input | 2 | Sleep state: 00 S0, 01 S1, 10 S3, 11 S4/S5 |
| lock_ovr_en_i | input | 1 | Lock-time override enable |
| lock_ovr_i | input | 2 | Override lock-time code |
| addr_i | input | 8 | Register bus address |
| wr_en_i | input | 1 | Register bus write strobe |
| wdata_i | input | 8 | Register bus write data |
| rdata_o | output | 8 | Register bus read data |
| lock_sel_o | output | 2 | Effective lock-time select |

## Verification
The assertions check the following on every cycle:
- the reserved bits read zero;
- off-offset reads return zero;
- the lock-select multiplexing;
- scratch-flag stability when no write hits A2h;
- warm-reset clearing;
- write-1-clear;
- set-over-clear priority;
- the power-good mask on the button fire pulse.

Only the bench scenarios can show the edge-only behaviour of the qualifier machines: a button held through the return of power good, and trips during S3 or platform reset. The same holds for survival of the flags across platform reset and for the full clear by the standby-rail reset.

// File: rtl/pm_status_pkg.sv
package pm_status_pkg;

    typedef enum logic [1:0] {
        QS_BLOCKED = 2'b00,
        QS_READY   = 2'b01,
        QS_ACTIVE  = 2'b10
    } qual_state_t;

    localparam int STAT_W   = 8;
    localparam int BIT_INIT = 7;
    localparam int LOCK_HI  = 6;
    localparam int LOCK_LO  = 5;
    localparam int BIT_BTN  = 4;
    localparam int BIT_TRIP = 3;
    localparam int LOCK_W   = LOCK_HI - LOCK_LO + 1;
    localparam int RSVD_W   = BIT_TRIP;

    localparam logic [1:0] SLP_S0 = 2'b00;
    localparam logic [1:0] SLP_S1 = 2'b01;

    localparam int EVT_BTN  = 0;
    localparam int EVT_TRIP = 1;
    localparam int NUM_EVT  = 2;

endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pm_evt_qual.sv
module pm_evt_qual
    import pm_status_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic evt_i,
    input  logic qual_i,
    output logic fire_o
);

    qual_state_t state_q;
    qual_state_t state_d;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            state_q <= QS_BLOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            QS_BLOCKED: begin
                if (qual_i) begin
                    state_d = evt_i ? QS_ACTIVE : QS_READY;
                end
            end
            QS_READY: begin
                if (!qual_i) begin
                    state_d = QS_BLOCKED;
                end else if (evt_i) begin
                    state_d = QS_ACTIVE;
                end
            end
            QS_ACTIVE: begin
                if (!qual_i) begin
                    state_d = QS_BLOCKED;
                end else if (!evt_i) begin
                    state_d = QS_READY;
                end
            end
            default: state_d = QS_BLOCKED;
        endcase
    end

    always_comb begin
        fire_o = 1'b0;
        unique case (state_q)
            QS_READY:   fire_o = qual_i && evt_i;
            QS_BLOCKED: fire_o = 1'b0;
            QS_ACTIVE:  fire_o = 1'b0;
            default:    fire_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pm_stat_regs.sv
module pm_stat_regs
    import pm_status_pkg::*;
(
    input  logic              clk_i,
    input  logic              rsm_rst_n_i,
    input  logic              warm_clr_i,
    input  logic              wr_hit_i,
    input  logic [STAT_W-1:0] wdata_i,
    input  logic              set_btn_i,
    input  logic              set_trip_i,
    output logic [STAT_W-1:0] stat_o
);

    logic              init_q;
    logic [LOCK_W-1:0] lock_q;
    logic              btn_q;
    logic              trip_q;

    logic clr_btn;
    logic clr_trip;

    assign clr_btn  = wr_hit_i && wdata_i[BIT_BTN];
    assign clr_trip = wr_hit_i && wdata_i[BIT_TRIP];

    // scratch flag: only the standby-rail reset domain
    always_ff @(posedge clk_i or negedge rsm_rst_n_i) begin
        if (!rsm_rst_n_i) begin
            init_q <= 1'b0;
        end else if (wr_hit_i) begin
            init_q <= wdata_i[BIT_INIT];
        end
    end

    // lock-time select: standby-rail and warm reset domains
    always_ff @(posedge clk_i or negedge rsm_rst_n_i) begin
        if (!rsm_rst_n_i) begin
            lock_q <= '0;
        end else if (warm_clr_i) begin
            lock_q <= '0;
        end else if (wr_hit_i) begin
            lock_q <= wdata_i[LOCK_HI:LOCK_LO];
        end
    end

    // sticky event flags: set beats write-1-clear
    always_ff @(posedge clk_i or negedge rsm_rst_n_i) begin
        if (!rsm_rst_n_i) begin
            btn_q  <= 1'b0;
            trip_q <= 1'b0;
        end else if (warm_clr_i) begin
            btn_q  <= 1'b0;
            trip_q <= 1'b0;
        end else begin
            if (set_btn_i) begin
                btn_q <= 1'b1;
            end else if (clr_btn) begin
                btn_q <= 1'b0;
            end
            if (set_trip_i) begin
                trip_q <= 1'b1;
            end else if (clr_trip) begin
                trip_q <= 1'b0;
            end
        end
    end

    assign stat_o = {init_q, lock_q, btn_q, trip_q, {RSVD_W{1'b0}}};

endmodule

// File: rtl/pm_status_reg.sv
module pm_status_reg
    import pm_status_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter logic [7:0]  REG_ADDR    = 8'hA2,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rsm_rst_n_i,
    input  logic              warm_rst_n_i,
    input  logic              plt_rst_n_i,
    input  logic              pwr_ok_i,
    input  logic              rst_btn_i,
    input  logic              therm_trip_i,
    input  logic [1:0]        slp_state_i,
    input  logic              lock_ovr_en_i,
    input  logic [1:0]        lock_ovr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic [1:0]        lock_sel_o
);

    localparam int SYNC_W = 6;

    logic [SYNC_W-1:0] raw_vec;
    logic [SYNC_W-1:0] syn_vec;
    logic [1:0]        slp_s;
    logic              plt_n_s;
    logic              pwr_ok_s;
    logic              btn_s;
    logic              trip_s;

    logic [NUM_EVT-1:0] evt_s;
    logic [NUM_EVT-1:0] evt_qual;
    logic [NUM_EVT-1:0] evt_fire;
    logic               btn_fire;
    logic               trip_fire;

    logic              reg_sel;
    logic              wr_hit;
    logic [STAT_W-1:0] stat_q;

    assign raw_vec = {slp_state_i, plt_rst_n_i, pwr_ok_i, rst_btn_i, therm_trip_i};

    pm_sync #(
        .WIDTH (SYNC_W),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_n_i(rsm_rst_n_i),
        .d_i    (raw_vec),
        .q_o    (syn_vec)
    );

    assign {slp_s, plt_n_s, pwr_ok_s, btn_s, trip_s} = syn_vec;

    assign evt_s[EVT_BTN]     = btn_s;
    assign evt_s[EVT_TRIP]    = trip_s;
    assign evt_qual[EVT_BTN]  = pwr_ok_s;
    assign evt_qual[EVT_TRIP] = plt_n_s && ((slp_s == SLP_S0) || (slp_s == SLP_S1));

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
        pm_evt_qual u_qual (
            .clk_i  (clk_i),
            .rst_n_i(rsm_rst_n_i),
            .evt_i  (evt_s[e]),
            .qual_i (evt_qual[e]),
            .fire_o (evt_fire[e])
        );
    end

    assign btn_fire  = evt_fire[EVT_BTN];
    assign trip_fire = evt_fire[EVT_TRIP];

    assign reg_sel = (addr_i == ADDR_W'(REG_ADDR));
    assign wr_hit  = reg_sel && wr_en_i;

    pm_stat_regs u_regs (
        .clk_i      (clk_i),
        .rsm_rst_n_i(rsm_rst_n_i),
        .warm_clr_i (!warm_rst_n_i),
        .wr_hit_i   (wr_hit),
        .wdata_i    (wdata_i),
        .set_btn_i  (btn_fire),
        .set_trip_i (trip_fire),
        .stat_o     (stat_q)
    );

    assign rdata_o    = reg_sel ? stat_q : '0;
    assign lock_sel_o = lock_ovr_en_i ? lock_ovr_i : stat_q[LOCK_HI:LOCK_LO];

endmodule

// File: rtl/pm_status_chk.sv
module pm_status_chk #(
    parameter int         ADDR_W   = 8,
    parameter logic [7:0] REG_ADDR = 8'hA2
) (
    input logic              clk,
    input logic              rsm_rst_n,
    input logic              warm_rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata,
    input logic [1:0]        lock_sel,
    input logic              ovr_en,
    input logic [1:0]        ovr,
    input logic [7:0]        stat_q,
    input logic              btn_fire,
    input logic              trip_fire,
    input logic              pwr_ok_s
);

    logic hit;
    assign hit = wr_en && (addr == ADDR_W'(REG_ADDR));

    assert_off_addr_R1: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        (addr != ADDR_W'(REG_ADDR)) |-> (rdata == 8'h00));

    assert_init_hold_R2: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        !$past(hit) |-> (stat_q[7] == $past(stat_q[7])));

    assert_lock_field_R3: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        (!ovr_en && addr == ADDR_W'(REG_ADDR)) |-> (lock_sel == rdata[6:5]));

    assert_lock_ovr_R4: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        ovr_en |-> (lock_sel == ovr));

    assert_w1c_R5: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        $past(hit && wdata[4] && !btn_fire) |-> !stat_q[4]);

    assert_btn_mask_R6: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        !pwr_ok_s |-> !btn_fire);

    assert_trip_set_R7: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        $past(warm_rst_n && trip_fire) |-> stat_q[3]);

    assert_warm_clr_R8: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        !$past(warm_rst_n) |-> (stat_q[6:3] == 4'b0000));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        $past(warm_rst_n && btn_fire && hit && wdata[4]) |-> stat_q[4]);

    assert_resv_zero_R10: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        rdata[2:0] == 3'b000);

endmodule

bind pm_status_reg pm_status_chk #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR)
) u_chk (
    .clk       (clk_i),
    .rsm_rst_n (rsm_rst_n_i),
    .warm_rst_n(warm_rst_n_i),
    .addr      (addr_i),
    .wr_en     (wr_en_i),
    .wdata     (wdata_i),
    .rdata     (rdata_o),
    .lock_sel  (lock_sel_o),
    .ovr_en    (lock_ovr_en_i),
    .ovr       (lock_ovr_i),
    .stat_q    (stat_q),
    .btn_fire  (btn_fire),
    .trip_fire (trip_fire),
    .pwr_ok_s  (pwr_ok_s)
);

// File: tb/pm_status_reg_test.sv
module pm_status_reg_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] OFF = 8'hA2;

    logic       clk_i = 1'b0;
    logic       rsm_rst_n_i = 1'b0;
    logic       warm_rst_n_i = 1'b1;
    logic       plt_rst_n_i = 1'b1;
    logic       pwr_ok_i = 1'b1;
    logic       rst_btn_i = 1'b0;
    logic       therm_trip_i = 1'b0;
    logic [1:0] slp_state_i = 2'b00;
    logic       lock_ovr_en_i = 1'b0;
    logic [1:0] lock_ovr_i = 2'b00;
    logic [7:0] addr_i = OFF;
    logic       wr_en_i = 1'b0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic [1:0] lock_sel_o;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done = 1'b0;

    int         q_kind[$];
    logic [7:0] q_exp[$];
    string      q_req[$];

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    pm_status_reg uut (
        .clk_i        (clk_i),
        .rsm_rst_n_i  (rsm_rst_n_i),
        .warm_rst_n_i (warm_rst_n_i),
        .plt_rst_n_i  (plt_rst_n_i),
        .pwr_ok_i     (pwr_ok_i),
        .rst_btn_i    (rst_btn_i),
        .therm_trip_i (therm_trip_i),
        .slp_state_i  (slp_state_i),
        .lock_ovr_en_i(lock_ovr_en_i),
        .lock_ovr_i   (lock_ovr_i),
        .addr_i       (addr_i),
        .wr_en_i      (wr_en_i),
        .wdata_i      (wdata_i),
        .rdata_o      (rdata_o),
        .lock_sel_o   (lock_sel_o)
    );

    // monitor: pops expected items and compares after the edge settles
    initial begin
        forever begin
            @(posedge clk_i);
            #(CLK_PERIOD/4);
            while (q_kind.size() > 0) begin
                automatic int         k = q_kind.pop_front();
                automatic logic [7:0] e = q_exp.pop_front();
                automatic string      r = q_req.pop_front();
                automatic logic [7:0] a = (k == 0) ? rdata_o : {6'b0, lock_sel_o};
                vectors++;
                if (a !== e) begin
                    miscompares++;
                    $display("FAIL %s: %s actual %02h expected %02h",
                             r, (k == 0) ? "rdata" : "lock_sel", a, e);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic exp_rd(input logic [7:0] a, input logic [7:0] e, input string r);
        @(negedge clk_i);
        addr_i = a;
        q_kind.push_back(0); q_exp.push_back(e); q_req.push_back(r);
        @(negedge clk_i);
        addr_i = OFF;
    endtask

    task automatic exp_lock(input logic [1:0] e, input string r);
        @(negedge clk_i);
        q_kind.push_back(1); q_exp.push_back({6'b0, e}); q_req.push_back(r);
        @(negedge clk_i);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk_i);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk_i);
        wr_en_i = 1'b0; addr_i = OFF;
    endtask

    task automatic pulse_btn();
        @(negedge clk_i); rst_btn_i = 1'b1; idle(5);
        rst_btn_i = 1'b0; idle(5);
    endtask

    task automatic pulse_trip();
        @(negedge clk_i); therm_trip_i = 1'b1; idle(5);
        therm_trip_i = 1'b0; idle(5);
    endtask

    initial begin
        forever begin
            @(posedge clk_i);
            cycles++;
            if (cycles > 20000 && !done) begin
                miscompares++;
                $display("FAIL watchdog expired");
                $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
                $finish;
            end
        end
    end

    initial begin
        idle(3);
        rsm_rst_n_i = 1'b1;
        idle(4);

        // R1: reset value and off-offset reads
        exp_rd(OFF, 8'h00, "R1");
        exp_lock(2'b00, "R3");

        // R2 R3 R10: write all ones; reserved stay 0, flags not set by writes
        wr(OFF, 8'hFF);
        exp_rd(OFF, 8'hE0, "R10");
        exp_rd(8'h10, 8'h00, "R1");
        wr(8'h10, 8'h00);
        exp_rd(OFF, 8'hE0, "R10");
        exp_lock(2'b11, "R3");

        // R4: override wins
        @(negedge clk_i); lock_ovr_en_i = 1'b1; lock_ovr_i = 2'b01;
        exp_lock(2'b01, "R4");
        @(negedge clk_i); lock_ovr_en_i = 1'b0;
        exp_lock(2'b11, "R4");

        // R5: button press sets, write 0 keeps, write 1 clears
        pulse_btn();
        exp_rd(OFF, 8'hF0, "R5");
        wr(OFF, 8'hE0);
        exp_rd(OFF, 8'hF0, "R5");
        wr(OFF, 8'hF0);
        exp_rd(OFF, 8'hE0, "R5");

        // R6: masked while power-good low, held button ignored on return
        @(negedge clk_i); pwr_ok_i = 1'b0; idle(4);
        rst_btn_i = 1'b1; idle(5);
        exp_rd(OFF, 8'hE0, "R6");
        pwr_ok_i = 1'b1; idle(5);
        exp_rd(OFF, 8'hE0, "R6");
        rst_btn_i = 1'b0; idle(5);
        exp_rd(OFF, 8'hE0, "R6");

        // R7: thermal trip qualification
        @(negedge clk_i); slp_state_i = 2'b10; idle(4);
        pulse_trip();
        exp_rd(OFF, 8'hE0, "R7");
        @(negedge clk_i); slp_state_i = 2'b00; plt_rst_n_i = 1'b0; idle(4);
        pulse_trip();
        exp_rd(OFF, 8'hE0, "R7");
        @(negedge clk_i); plt_rst_n_i = 1'b1; slp_state_i = 2'b01; idle(4);
        pulse_trip();
        exp_rd(OFF, 8'hE8, "R7");

        // R8: platform reset keeps flags; warm reset clears 6:3, keeps 7
        @(negedge clk_i); plt_rst_n_i = 1'b0; idle(5);
        plt_rst_n_i = 1'b1; idle(5);
        exp_rd(OFF, 8'hE8, "R8");
        pulse_btn();
        exp_rd(OFF, 8'hF8, "R8");
        @(negedge clk_i); warm_rst_n_i = 1'b0; idle(2);
        warm_rst_n_i = 1'b1; idle(2);
        exp_rd(OFF, 8'h80, "R8");
        exp_lock(2'b00, "R3");

        // R9: set and write-1-clear in the same cycle
        @(negedge clk_i); rst_btn_i = 1'b1;
        @(posedge clk_i); @(posedge clk_i);
        @(negedge clk_i); addr_i = OFF; wdata_i = 8'h90; wr_en_i = 1'b1;
        @(negedge clk_i); wr_en_i = 1'b0; rst_btn_i = 1'b0;
        idle(4);
        exp_rd(OFF, 8'h90, "R9");

        // R1 R2: standby-rail reset clears everything including bit 7
        @(negedge clk_i); rsm_rst_n_i = 1'b0; idle(2);
        rsm_rst_n_i = 1'b1; idle(3);
        exp_rd(OFF, 8'h00, "R2");

        idle(3);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule